// File: doc/BRIEF.md
# Software Flow Control Engine for a Serial Channel

This block adds character-based flow control to one serial channel. Each received character is compared with two programmable 8-bit codes: a "resume" code (Xon) and a "stop" code (Xoff). When receive-driven flow control is enabled, a received stop code halts the transmitter at the next character boundary, and a received resume code lets it continue.

The block can also generate flow control automatically. It watches the fill level of the receive FIFO. When the level climbs to a high threshold, it queues a stop code for transmission. When the level falls back to a low threshold, it queues a resume code. A queued code goes ahead of the next data character from the transmit FIFO.

An 8-bit status word reports four 2-bit fields, each with its own clearing rule. An event output stays high while received-code status is pending. The transmit side works through a handshake: the external shifter raises `tx_idle` at a character boundary, and the block answers with a one-cycle `tx_load` pulse. The transmit FIFO is first-word-fall-through: its head word is on `txf_data`, and `txf_pop` removes it.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset the resume code register holds 0x11 and the stop code register holds 0x13. Pulsing `xon_wr` or `xoff_wr` loads `chr_wdata` into that register, and later comparisons use the new value.
- R2: `stat_word[7:6]` reports received codes. Bit 6 is set by a stop code and bit 7 by a resume code, so the field reads 00 none, 01 stop seen, 10 resume seen, 11 both. It is set whatever `flow_en` and `auto_en` are, holds until a `stat_rd` pulse, and a match in the same cycle as the read survives the read. `x_evt` is high exactly while this field is nonzero.
- R3: `stat_word[5:4]` reports the last code sent automatically: 00 none, 01 resume sent, 10 stop sent. It never reads 11.
- R4: When `auto_en` is low, `stat_word[5:4]` reads 00 from the next cycle on, and all queued codes are dropped.
- R5: `stat_word[3:2]` is the transmit flow state: 00 normal, 01 halt pending, 10 re-enabled, 11 halted. With `flow_en` high, a stop code received while `tx_idle` is high gives 11 at once. While the state is 01 or 11, no data character is loaded.
- R6: A stop code received while the shifter is busy (`tx_idle` low) gives 01. The state becomes 11 in the cycle after `tx_idle` rises.
- R7: A resume code received in state 11 gives 10, and data loading resumes. State 10 returns to 00 on a `stat_rd` pulse. Dropping `flow_en` returns the state to 00, and with `flow_en` low, received codes do not change the state.
- R8: `stat_word[1:0]` is the character status: 10 stop code queued, 11 resume code queued, 01 waiting for data after a flow code was loaded, 00 normal data. Waiting lasts until the next data character is loaded.
- R9: With `auto_en` high, a stop code is queued when `rxf_level` >= `HI_THR` and the last code sent was not a stop. A resume code is queued when `rxf_level` <= `LO_THR` after a stop was sent.
- R10: At a character boundary, a queued flow code is loaded before any data character, even while the transmitter is halted. A flow code load does not pop the transmit FIFO.
- R11: `tx_load` never stays high for two cycles in a row. `txf_pop` is high only together with `tx_load` for a data character.
- R12: After reset, `stat_word`, `x_evt`, `tx_load` and `txf_pop` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xon_wr | input | 1 | Load resume code register |
| xoff_wr | input | 1 | Load stop code register |
| chr_wdata | input | 8 | Code value to load |
| flow_en | input | 1 | Enable halting and resuming on received codes |
| auto_en | input | 1 | Enable automatic code generation from the receive FIFO level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rxf_level | input | 5 | Receive FIFO fill level |
| txf_empty | input | 1 | Transmit FIFO is empty |
| txf_data | input | 8 | Head word of the transmit FIFO |
| txf_pop | output | 1 | Remove the head word from the transmit FIFO |
| tx_idle | input | 1 | Shifter is at a character boundary and can take a character |
| tx_load | output | 1 | One-cycle pulse handing `tx_char` to the shifter |
| tx_char | output | 8 | Character handed to the shifter |
| stat_rd | input | 1 | Status read strobe; applies the read-clear rules |
| stat_word | output | 8 | {received, auto-sent, flow state, character status} |
| x_evt | output | 1 | Received-code event, for interrupt use |

## Verification
The assertions assume the shifter drops `tx_idle` in the cycle after it sees `tx_load` and keeps it low while it shifts. They also assume `stat_rd` and the write strobes are single-cycle pulses. The bench models the shifter with a grab task: it raises `tx_idle`, waits for the load pulse, and lowers `tx_idle` again on the next falling edge. The bench changes the FIFO level, the enables and the received characters only on falling edges, and only while no load is outstanding. This keeps every stimulus within what the checker assumes.

// File: rtl/xflow_pkg.sv
package xflow_pkg;
  typedef enum logic [1:0] {
    FS_NORMAL = 2'b00,
    FS_PEND   = 2'b01,
    FS_REEN   = 2'b10,
    FS_HALT   = 2'b11
  } flow_st_e;

  typedef enum logic [1:0] {
    AT_NONE = 2'b00,
    AT_XON  = 2'b01,
    AT_XOFF = 2'b10
  } auto_st_e;

  typedef enum logic [1:0] {
    CS_DATA = 2'b00,
    CS_WAIT = 2'b01,
    CS_XOFF = 2'b10,
    CS_XON  = 2'b11
  } chr_st_e;
endpackage

// File: rtl/xflow_rxcmp.sv
module xflow_rxcmp #(
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_RST  = 8'h11,
  parameter logic [DW-1:0] XOFF_RST = 8'h13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xon_wr,
  input  logic          xoff_wr,
  input  logic [DW-1:0] chr_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          stat_rd,
  output logic [DW-1:0] xon_chr,
  output logic [DW-1:0] xoff_chr,
  output logic          hit_xon,
  output logic          hit_xoff,
  output logic [1:0]    rx_field,
  output logic          x_evt
);
  logic [1:0] rx_nxt;

  // code registers
  always_ff @(posedge clk) begin
    if (rst) begin
      xon_chr  <= XON_RST;
      xoff_chr <= XOFF_RST;
    end else begin
      if (xon_wr)  xon_chr  <= chr_wdata;
      if (xoff_wr) xoff_chr <= chr_wdata;
    end
  end

  assign hit_xon  = rx_valid && (rx_char == xon_chr);
  assign hit_xoff = rx_valid && (rx_char == xoff_chr);

  // read clears first, a match in the same cycle is kept
  always_comb begin
    rx_nxt = stat_rd ? 2'b00 : rx_field;
    if (hit_xoff) rx_nxt[0] = 1'b1;
    if (hit_xon)  rx_nxt[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_field <= 2'b00;
      x_evt    <= 1'b0;
    end else begin
      rx_field <= rx_nxt;
      x_evt    <= |rx_nxt;
    end
  end
endmodule

// File: rtl/xflow_auto.sv
module xflow_auto
  import xflow_pkg::*;
#(
  parameter int LVLW = 5,
  parameter int HI_THR = 12,
  parameter int LO_THR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            auto_en,
  input  logic [LVLW-1:0] rxf_level,
  input  logic            sent_xon,
  input  logic            sent_xoff,
  output logic            xon_pend,
  output logic            xoff_pend,
  output logic [1:0]      auto_field
);
  localparam logic [LVLW-1:0] HI_L = LVLW'(HI_THR);
  localparam logic [LVLW-1:0] LO_L = LVLW'(LO_THR);

  auto_st_e ats;
  logic     idle_q;
  logic     want_off, want_on;

  assign idle_q   = !xon_pend && !xoff_pend;
  assign want_off = idle_q && (rxf_level >= HI_L) && (ats != AT_XOFF);
  assign want_on  = idle_q && (rxf_level <= LO_L) && (ats == AT_XOFF);

  always_ff @(posedge clk) begin
    if (rst || !auto_en) begin
      ats       <= AT_NONE;
      xon_pend  <= 1'b0;
      xoff_pend <= 1'b0;
    end else begin
      if (sent_xoff) begin
        ats       <= AT_XOFF;
        xoff_pend <= 1'b0;
      end else if (want_off) begin
        xoff_pend <= 1'b1;
      end
      if (sent_xon) begin
        ats      <= AT_XON;
        xon_pend <= 1'b0;
      end else if (want_on) begin
        xon_pend <= 1'b1;
      end
    end
  end

  assign auto_field = ats;
endmodule

// File: rtl/xflow_txsel.sv
module xflow_txsel
  import xflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic          hit_xon,
  input  logic          hit_xoff,
  input  logic          stat_rd,
  input  logic          tx_idle,
  input  logic          txf_empty,
  input  logic [DW-1:0] txf_data,
  input  logic          xon_pend,
  input  logic          xoff_pend,
  input  logic [DW-1:0] xon_chr,
  input  logic [DW-1:0] xoff_chr,
  output logic          tx_load,
  output logic [DW-1:0] tx_char,
  output logic          txf_pop,
  output logic          sent_xon,
  output logic          sent_xoff,
  output logic [1:0]    flow_field,
  output logic [1:0]    chr_field
);
  flow_st_e fs, fs_nxt;
  logic     wait_q;
  logic     bound, blocked, send_dat;

  // a boundary is a shifter that is idle and not just loaded
  assign bound   = tx_idle && !tx_load;
  assign blocked = (fs == FS_HALT) || (fs == FS_PEND) || (flow_en && hit_xoff);

  assign sent_xoff = bound && xoff_pend;
  assign sent_xon  = bound && !xoff_pend && xon_pend;
  assign send_dat  = bound && !xoff_pend && !xon_pend && !blocked && !txf_empty;

  always_comb begin
    fs_nxt = fs;
    if (!flow_en) begin
      fs_nxt = FS_NORMAL;
    end else if (hit_xoff) begin
      if (fs != FS_HALT) fs_nxt = bound ? FS_HALT : FS_PEND;
    end else if (hit_xon) begin
      case (fs)
        FS_HALT: fs_nxt = FS_REEN;
        FS_PEND: fs_nxt = FS_NORMAL;
        default: fs_nxt = fs;
      endcase
    end else begin
      case (fs)
        FS_PEND: if (bound)   fs_nxt = FS_HALT;
        FS_REEN: if (stat_rd) fs_nxt = FS_NORMAL;
        default: fs_nxt = fs;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs      <= FS_NORMAL;
      wait_q  <= 1'b0;
      tx_load <= 1'b0;
      txf_pop <= 1'b0;
      tx_char <= '0;
    end else begin
      fs      <= fs_nxt;
      tx_load <= sent_xoff || sent_xon || send_dat;
      txf_pop <= send_dat;
      if (sent_xoff)     tx_char <= xoff_chr;
      else if (sent_xon) tx_char <= xon_chr;
      else if (send_dat) tx_char <= txf_data;
      if (sent_xoff || sent_xon) wait_q <= 1'b1;
      else if (send_dat)         wait_q <= 1'b0;
    end
  end

  assign flow_field = fs;

  always_comb begin
    if (xoff_pend)     chr_field = CS_XOFF;
    else if (xon_pend) chr_field = CS_XON;
    else if (wait_q)   chr_field = CS_WAIT;
    else               chr_field = CS_DATA;
  end
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl #(
  parameter int DW = 8,
  parameter int LVLW = 5,
  parameter int HI_THR = 12,
  parameter int LO_THR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xon_wr,
  input  logic            xoff_wr,
  input  logic [DW-1:0]   chr_wdata,
  input  logic            flow_en,
  input  logic            auto_en,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_char,
  input  logic [LVLW-1:0] rxf_level,
  input  logic            txf_empty,
  input  logic [DW-1:0]   txf_data,
  output logic            txf_pop,
  input  logic            tx_idle,
  output logic            tx_load,
  output logic [DW-1:0]   tx_char,
  input  logic            stat_rd,
  output logic [7:0]      stat_word,
  output logic            x_evt
);
  logic [DW-1:0] xon_chr, xoff_chr;
  logic          hit_xon, hit_xoff;
  logic          xon_pend, xoff_pend, sent_xon, sent_xoff;
  logic [1:0]    rx_field, auto_field, flow_field, chr_field;

  xflow_rxcmp #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .xon_wr(xon_wr), .xoff_wr(xoff_wr),
    .chr_wdata(chr_wdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .stat_rd(stat_rd), .xon_chr(xon_chr), .xoff_chr(xoff_chr),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .rx_field(rx_field),
    .x_evt(x_evt)
  );

  xflow_auto #(.LVLW(LVLW), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_auto (
    .clk(clk), .rst(rst), .auto_en(auto_en), .rxf_level(rxf_level),
    .sent_xon(sent_xon), .sent_xoff(sent_xoff), .xon_pend(xon_pend),
    .xoff_pend(xoff_pend), .auto_field(auto_field)
  );

  xflow_txsel #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .flow_en(flow_en), .hit_xon(hit_xon),
    .hit_xoff(hit_xoff), .stat_rd(stat_rd), .tx_idle(tx_idle),
    .txf_empty(txf_empty), .txf_data(txf_data), .xon_pend(xon_pend),
    .xoff_pend(xoff_pend), .xon_chr(xon_chr), .xoff_chr(xoff_chr),
    .tx_load(tx_load), .tx_char(tx_char), .txf_pop(txf_pop),
    .sent_xon(sent_xon), .sent_xoff(sent_xoff),
    .flow_field(flow_field), .chr_field(chr_field)
  );

  assign stat_word = {rx_field, auto_field, flow_field, chr_field};
endmodule

// File: rtl/xflow_ctrl_chk.sv
module xflow_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       auto_en,
  input logic       rx_valid,
  input logic       stat_rd,
  input logic       tx_load,
  input logic       txf_pop,
  input logic [7:0] stat_word,
  input logic       x_evt
);
  a_r3_auto_never_11: assert property (@(posedge clk) disable iff (rst)
    stat_word[5:4] != 2'b11);

  a_r4_auto_off_clears: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> stat_word[5:4] == 2'b00);

  a_r5_no_data_when_halted: assert property (@(posedge clk) disable iff (rst)
    (stat_word[3:2] == 2'b11 || stat_word[3:2] == 2'b01) |=> !txf_pop);

  a_r11_pop_with_load: assert property (@(posedge clk) disable iff (rst)
    txf_pop |-> tx_load);

  a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);

  a_r2_evt_tracks_field: assert property (@(posedge clk) disable iff (rst)
    x_evt == (stat_word[7:6] != 2'b00));

  a_r2_field_holds: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && !rx_valid) |=> $stable(stat_word[7:6]));
endmodule

bind xflow_ctrl xflow_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .auto_en(auto_en), .rx_valid(rx_valid),
  .stat_rd(stat_rd), .tx_load(tx_load), .txf_pop(txf_pop),
  .stat_word(stat_word), .x_evt(x_evt)
);

// File: tb/xflow_ctrl_test.sv
module xflow_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xon_wr = 1'b0, xoff_wr = 1'b0;
  logic [7:0] chr_wdata = 8'h00;
  logic       flow_en = 1'b0, auto_en = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [4:0] rxf_level = 5'd8;
  logic       txf_empty = 1'b1;
  logic [7:0] txf_data = 8'hA5;
  logic       txf_pop, tx_load, x_evt;
  logic       tx_idle = 1'b0;
  logic [7:0] tx_char, stat_word;
  logic       stat_rd = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xflow_ctrl uut (
    .clk(clk), .rst(rst), .xon_wr(xon_wr), .xoff_wr(xoff_wr),
    .chr_wdata(chr_wdata), .flow_en(flow_en), .auto_en(auto_en),
    .rx_valid(rx_valid), .rx_char(rx_char), .rxf_level(rxf_level),
    .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
    .tx_idle(tx_idle), .tx_load(tx_load), .tx_char(tx_char),
    .stat_rd(stat_rd), .stat_word(stat_word), .x_evt(x_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] c);
    rx_char = c; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic grab(output logic [7:0] c, output logic pop);
    c = 8'hxx; pop = 1'b0;
    tx_idle = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_load) begin
        c = tx_char; pop = txf_pop; break;
      end
    end
    tx_idle = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 stat_word", stat_word, 8'h00);
    chk("R12 x_evt", x_evt, 0);
    chk("R12 tx_load", tx_load, 0);
    chk("R12 txf_pop", txf_pop, 0);
  endtask

  task automatic t_match();
    rx_send(8'h13);
    chk("R2 stop seen", stat_word[7:6], 2'b01);
    chk("R2 evt", x_evt, 1);
    chk("R7 flow off no effect", stat_word[3:2], 2'b00);
    rx_send(8'h41);
    chk("R2 other char", stat_word[7:6], 2'b01);
    rx_send(8'h11);
    chk("R2 both seen", stat_word[7:6], 2'b11);
    rd();
    chk("R2 read clears", stat_word[7:6], 2'b00);
    chk("R2 evt cleared", x_evt, 0);
    rx_send(8'h11);
    chk("R2 resume seen", stat_word[7:6], 2'b10);
    rx_char = 8'h13; rx_valid = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; stat_rd = 1'b0;
    chk("R2 match survives read", stat_word[7:6], 2'b01);
    rd();
    chdr_write();
    rx_send(8'h55);
    chk("R1 new stop code", stat_word[7:6], 2'b01);
    rd();
    rx_send(8'h13);
    chk("R1 old code ignored", stat_word[7:6], 2'b00);
    chr_wdata = 8'h13; xoff_wr = 1'b1;
    @(negedge clk);
    xoff_wr = 1'b0;
  endtask

  task automatic chdr_write();
    chr_wdata = 8'h55; xoff_wr = 1'b1;
    @(negedge clk);
    xoff_wr = 1'b0;
  endtask

  task automatic t_halt();
    logic [7:0] c; logic p; int loads;
    flow_en = 1'b1; txf_empty = 1'b1; tx_idle = 1'b1;
    @(negedge clk);
    rx_send(8'h13);
    chk("R5 halted at once", stat_word[3:2], 2'b11);
    txf_empty = 1'b0; loads = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_load) loads++;
    end
    chk("R5 no data while halted", loads, 0);
    tx_idle = 1'b0;
    rx_send(8'h11);
    chk("R7 re-enabled", stat_word[3:2], 2'b10);
    grab(c, p);
    chk("R7 data resumes", c, 8'hA5);
    chk("R11 data pops", p, 1);
    chk("R7 still re-enabled", stat_word[3:2], 2'b10);
    rd();
    chk("R7 read to normal", stat_word[3:2], 2'b00);
    txf_empty = 1'b1;
  endtask

  task automatic t_pend();
    logic [7:0] c; logic p;
    tx_idle = 1'b0; txf_empty = 1'b0;
    @(negedge clk);
    rx_send(8'h13);
    chk("R6 halt pending", stat_word[3:2], 2'b01);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R6 halted after boundary", stat_word[3:2], 2'b11);
    chk("R5 no load at boundary", tx_load, 0);
    tx_idle = 1'b0;
    rx_send(8'h11);
    grab(c, p);
    flow_en = 1'b0;
    @(negedge clk);
    chk("R7 flow_en low normal", stat_word[3:2], 2'b00);
    rd();
    txf_empty = 1'b1;
  endtask

  task automatic t_auto();
    logic [7:0] c; logic p;
    tx_idle = 1'b0; txf_empty = 1'b0;
    chk("R4 auto off reads 00", stat_word[5:4], 2'b00);
    auto_en = 1'b1; rxf_level = 5'd12;
    @(negedge clk);
    @(negedge clk);
    chk("R9 stop queued", stat_word[1:0], 2'b10);
    chk("R3 nothing sent yet", stat_word[5:4], 2'b00);
    grab(c, p);
    chk("R10 stop code first", c, 8'h13);
    chk("R10 no pop for code", p, 0);
    chk("R3 stop sent", stat_word[5:4], 2'b10);
    chk("R8 waiting", stat_word[1:0], 2'b01);
    grab(c, p);
    chk("R10 data next", c, 8'hA5);
    chk("R8 normal data", stat_word[1:0], 2'b00);
    txf_empty = 1'b1; rxf_level = 5'd4;
    @(negedge clk);
    @(negedge clk);
    chk("R9 resume queued", stat_word[1:0], 2'b11);
    grab(c, p);
    chk("R9 resume code sent", c, 8'h11);
    chk("R3 resume sent", stat_word[5:4], 2'b01);
    chk("R8 waiting empty fifo", stat_word[1:0], 2'b01);
    auto_en = 1'b0;
    @(negedge clk);
    chk("R4 disable clears", stat_word[5:4], 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_match();
    t_halt();
    t_pend();
    t_auto();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule